// File: doc/BRIEF.md
# SPI Descriptor Chain Sequencer

This block walks a linked list of transfer descriptors held in system memory and hands them, one at a time, to an SPI shift engine. Each descriptor is six 32-bit words, 24 bytes in all. The words are a command word, a bus-setting word, a 64-bit transmit buffer address and a 64-bit receive buffer address. Each 64-bit address is stored with its low word first. The sequencer reads the six words through a read port that has one request outstanding at a time. It pulses the engine to start, then waits for the engine's done strobe. It continues with the descriptor that follows in memory until it has executed a descriptor that carries the end-of-chain flag.

Software owns the block through a small register bus that decodes 5-bit byte offsets:

| Offset | Register |
|--------|----------|
| 0x00 | claim flag |
| 0x04 | configuration (bit 0 = sync start enable) |
| 0x08 | list base address |
| 0x0C | launch/control (bit 31 = go / busy) |
| 0x10 | current descriptor address |
| 0x14 | event status (write 1 to clear) |
| 0x18 | event enable |

A chain starts in one of two ways: software writes the control register with bit 31 set, or a rising edge arrives on the frame-sync input while sync start is enabled. Event status bit 8 reports a descriptor error, bit 10 reports that one descriptor has finished and bit 11 reports that the whole chain has finished.

The control state machine has four states:

- **IDLE**: goes to FETCH on a launch.
- **FETCH**: issues word reads at the current descriptor address. After the sixth word it goes to LAUNCH.
- **LAUNCH**: goes back to IDLE when the block count is zero. Otherwise it pulses the engine start and goes to WAIT.
- **WAIT**: on the engine's done strobe it goes to IDLE at end of chain, or back to FETCH with the address advanced by 24.

A control write with bit 31 clear is an abort. It forces IDLE from any state.

Top module: `spi_chain_seq`

## Requirements
- R1: After reset the claim flag reads 1, status, enable and control read 0, and irq, mem_req and eng_start are low.
- R2: A write to offset 0x00 stores bit 0 of the write data into the claim flag (0 = claimed, 1 = free). It does not launch a chain and does not change status.
- R3: A control write with bit 31 set while idle starts fetching at the list base. Word k of a descriptor is read at descriptor address + 4k (k = 0..5). mem_addr stays stable until mem_valid. Control bit 31 reads 1 while a chain is active.
- R4: The six words are passed on as follows: word 0 to eng_cmd, word 1 to eng_bus, words 3:2 to eng_tx_addr and words 5:4 to eng_rx_addr. eng_start is a single-cycle pulse.
- R5: On eng_done, status bit 10 is set. If command bit 30 is clear, the next descriptor is fetched at the current address + 24.
- R6: On eng_done for a descriptor with command bit 30 set, status bits 10 and 11 are set and the block returns to idle (control bit 31 reads 0).
- R7: A descriptor whose block count (command bits 19:0) is zero sets status bit 8, never pulses eng_start and ends the chain without setting bit 11.
- R8: A control write with bit 31 clear aborts the chain. The block goes idle, makes no further reads or starts and leaves status unchanged. A later eng_done is ignored.
- R9: With configuration bit 0 set, a rising edge on sync_in launches the chain at the list base. With bit 0 clear, sync_in has no effect.
- R10: Writing 1 to a status bit clears it. Status bits written with 0 keep their value.
- R11: irq is the OR of the status bits ANDed with the enable register. It stays high until the enabled bits are cleared or masked.
- R12: Offset 0x10 reads the address of the descriptor being fetched or executed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| reg_wr | input | 1 | register write strobe |
| reg_addr | input | REG_AW | register byte offset |
| reg_wdata | input | 32 | register write data |
| reg_rdata | output | 32 | register read data (combinational) |
| sync_in | input | 1 | external frame-sync start input |
| mem_req | output | 1 | descriptor word read request |
| mem_addr | output | AW | descriptor word byte address |
| mem_valid | input | 1 | read data valid, completes the request |
| mem_rdata | input | 32 | read data |
| eng_start | output | 1 | one-cycle start pulse to the shift engine |
| eng_cmd | output | 32 | descriptor command word |
| eng_bus | output | 32 | descriptor bus-setting word |
| eng_tx_addr | output | 64 | transmit buffer address |
| eng_rx_addr | output | 64 | receive buffer address |
| eng_done | input | 1 | engine finished the current descriptor |
| irq | output | 1 | level interrupt |

## Verification
A wrong word index or a wrong descriptor pointer appears on mem_addr at the next read request, within two clocks. The bench compares mem_addr on every request against its own running pointer. A wrong state shows up in one of three ways:

- a start pulse where none is due;
- a missing or surplus read;
- a control busy bit that disagrees with the chain's progress.

Each of these is visible at the ports within one descriptor. Status and irq errors show up at the next register read after the event that should have set or cleared them.

// File: rtl/spi_chain_pkg.sv
package spi_chain_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_LAUNCH,
        ST_WAIT
    } seq_state_t;

    localparam int DESC_WORDS = 6;
    localparam int DESC_BYTES = 4 * DESC_WORDS;
    localparam int WORD_IDX_W = $clog2(DESC_WORDS);

    localparam int OFS_READY = 'h00;
    localparam int OFS_CFG   = 'h04;
    localparam int OFS_BASE  = 'h08;
    localparam int OFS_CTRL  = 'h0C;
    localparam int OFS_CUR   = 'h10;
    localparam int OFS_STS   = 'h14;
    localparam int OFS_EN    = 'h18;

    localparam int BIT_GO    = 31;
    localparam int BIT_EOC   = 30;
    localparam int BLK_W     = 20;

    localparam int STS_W     = 12;
    localparam int STS_ERR   = 8;
    localparam int STS_DESC  = 10;
    localparam int STS_CHAIN = 11;

endpackage

// File: rtl/spi_chain_fsm.sv
module spi_chain_fsm
    import spi_chain_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          launch,
    input  logic          abort,
    input  logic [AW-1:0] list_base,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    input  logic          mem_valid,
    input  logic [31:0]   mem_rdata,
    output logic          eng_start,
    output logic [31:0]   eng_cmd,
    output logic [31:0]   eng_bus,
    output logic [63:0]   eng_tx_addr,
    output logic [63:0]   eng_rx_addr,
    input  logic          eng_done,
    output logic          busy,
    output logic [AW-1:0] cur_addr,
    output logic          ev_desc,
    output logic          ev_chain,
    output logic          ev_err
);

    seq_state_t            state_q, state_d;
    logic [WORD_IDX_W-1:0] idx_q;
    logic [AW-1:0]         cur_q;
    logic                  take, last_word, blk_zero, eoc;

    assign take      = (state_q == ST_FETCH) && mem_valid;
    assign last_word = (idx_q == WORD_IDX_W'(DESC_WORDS - 1));

    // one capture register per descriptor word
    for (genvar g = 0; g < DESC_WORDS; g++) begin : g_word
        logic [31:0] w_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                w_q <= '0;
            else if (take && idx_q == WORD_IDX_W'(g))
                w_q <= mem_rdata;
        end
    end

    assign eng_cmd     = g_word[0].w_q;
    assign eng_bus     = g_word[1].w_q;
    assign eng_tx_addr = {g_word[3].w_q, g_word[2].w_q};
    assign eng_rx_addr = {g_word[5].w_q, g_word[4].w_q};
    assign blk_zero    = (g_word[0].w_q[BLK_W-1:0] == '0);
    assign eoc         = g_word[0].w_q[BIT_EOC];

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (launch) state_d = ST_FETCH;
            ST_FETCH:  if (take && last_word) state_d = ST_LAUNCH;
            ST_LAUNCH: state_d = blk_zero ? ST_IDLE : ST_WAIT;
            ST_WAIT:   if (eng_done) state_d = eoc ? ST_IDLE : ST_FETCH;
            default:   state_d = ST_IDLE;
        endcase
        if (abort) state_d = ST_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
            cur_q <= '0;
        end else if (abort) begin
            idx_q <= '0;
        end else if (state_q == ST_IDLE && launch) begin
            idx_q <= '0;
            cur_q <= list_base;
        end else if (take) begin
            idx_q <= last_word ? '0 : idx_q + 1'b1;
        end else if (state_q == ST_WAIT && eng_done && !eoc) begin
            cur_q <= cur_q + AW'(DESC_BYTES);
        end
    end

    always_comb begin
        mem_req   = (state_q == ST_FETCH);
        mem_addr  = cur_q + AW'({idx_q, 2'b00});
        eng_start = (state_q == ST_LAUNCH) && !blk_zero && !abort;
        ev_err    = (state_q == ST_LAUNCH) && blk_zero && !abort;
        ev_desc   = (state_q == ST_WAIT) && eng_done && !abort;
        ev_chain  = ev_desc && eoc;
        busy      = (state_q != ST_IDLE);
        cur_addr  = cur_q;
    end

    p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_valid && !abort) |=> (mem_req && $stable(mem_addr)));

    p_start_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |=> !eng_start);

    p_no_zero_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> (eng_cmd[BLK_W-1:0] != '0));

    p_abort_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> !busy);

endmodule

// File: rtl/spi_chain_regs.sv
module spi_chain_regs
    import spi_chain_pkg::*;
#(
    parameter int AW     = 32,
    parameter int REG_AW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              sync_in,
    input  logic              busy,
    input  logic [AW-1:0]     cur_addr,
    input  logic              ev_desc,
    input  logic              ev_chain,
    input  logic              ev_err,
    output logic              launch,
    output logic              abort,
    output logic [AW-1:0]     list_base,
    output logic              irq
);

    localparam logic [STS_W-1:0] STS_MASK =
        STS_W'((1 << STS_ERR) | (1 << STS_DESC) | (1 << STS_CHAIN));

    logic             ready_q, sync_en_q, sync_q;
    logic [AW-1:0]    base_q;
    logic [STS_W-1:0] sts_q, en_q, set_vec, clr_vec;
    logic             wr_ready, wr_cfg, wr_base, wr_ctrl, wr_sts, wr_en, sync_rise;

    assign wr_ready  = reg_wr && reg_addr == REG_AW'(OFS_READY);
    assign wr_cfg    = reg_wr && reg_addr == REG_AW'(OFS_CFG);
    assign wr_base   = reg_wr && reg_addr == REG_AW'(OFS_BASE);
    assign wr_ctrl   = reg_wr && reg_addr == REG_AW'(OFS_CTRL);
    assign wr_sts    = reg_wr && reg_addr == REG_AW'(OFS_STS);
    assign wr_en     = reg_wr && reg_addr == REG_AW'(OFS_EN);
    assign sync_rise = sync_in && !sync_q && sync_en_q;

    assign launch    = ((wr_ctrl && reg_wdata[BIT_GO]) || sync_rise) && !busy;
    assign abort     = wr_ctrl && !reg_wdata[BIT_GO];
    assign list_base = base_q;
    assign irq       = |(sts_q & en_q);

    always_comb begin
        set_vec            = '0;
        set_vec[STS_ERR]   = ev_err;
        set_vec[STS_DESC]  = ev_desc;
        set_vec[STS_CHAIN] = ev_chain;
        clr_vec            = wr_sts ? reg_wdata[STS_W-1:0] : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ready_q   <= 1'b1;
            sync_en_q <= 1'b0;
            sync_q    <= 1'b0;
            base_q    <= '0;
            sts_q     <= '0;
            en_q      <= '0;
        end else begin
            sync_q <= sync_in;
            sts_q  <= (sts_q & ~clr_vec) | set_vec;
            if (wr_ready) ready_q   <= reg_wdata[0];
            if (wr_cfg)   sync_en_q <= reg_wdata[0];
            if (wr_base)  base_q    <= reg_wdata[AW-1:0];
            if (wr_en)    en_q      <= reg_wdata[STS_W-1:0] & STS_MASK;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            REG_AW'(OFS_READY): reg_rdata[0]        = ready_q;
            REG_AW'(OFS_CFG):   reg_rdata[0]        = sync_en_q;
            REG_AW'(OFS_BASE):  reg_rdata           = 32'(base_q);
            REG_AW'(OFS_CTRL):  reg_rdata[BIT_GO]   = busy;
            REG_AW'(OFS_CUR):   reg_rdata           = 32'(cur_addr);
            REG_AW'(OFS_STS):   reg_rdata[STS_W-1:0] = sts_q;
            REG_AW'(OFS_EN):    reg_rdata[STS_W-1:0] = en_q;
            default:            reg_rdata           = '0;
        endcase
    end

    p_ready_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ready |=> (ready_q == $past(reg_wdata[0])));

    p_w1c_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sts && reg_wdata[STS_DESC] && !ev_desc) |=> !sts_q[STS_DESC]);

    p_irq_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !reg_wr) |=> irq);

endmodule

// File: rtl/spi_chain_seq.sv
module spi_chain_seq
    import spi_chain_pkg::*;
#(
    parameter int AW     = 32,
    parameter int REG_AW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              sync_in,
    output logic              mem_req,
    output logic [AW-1:0]     mem_addr,
    input  logic              mem_valid,
    input  logic [31:0]       mem_rdata,
    output logic              eng_start,
    output logic [31:0]       eng_cmd,
    output logic [31:0]       eng_bus,
    output logic [63:0]       eng_tx_addr,
    output logic [63:0]       eng_rx_addr,
    input  logic              eng_done,
    output logic              irq
);

    logic          launch, abort, busy, ev_desc, ev_chain, ev_err;
    logic [AW-1:0] list_base, cur_addr;

    spi_chain_regs #(.AW(AW), .REG_AW(REG_AW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .sync_in   (sync_in),
        .busy      (busy),
        .cur_addr  (cur_addr),
        .ev_desc   (ev_desc),
        .ev_chain  (ev_chain),
        .ev_err    (ev_err),
        .launch    (launch),
        .abort     (abort),
        .list_base (list_base),
        .irq       (irq)
    );

    spi_chain_fsm #(.AW(AW)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .launch      (launch),
        .abort       (abort),
        .list_base   (list_base),
        .mem_req     (mem_req),
        .mem_addr    (mem_addr),
        .mem_valid   (mem_valid),
        .mem_rdata   (mem_rdata),
        .eng_start   (eng_start),
        .eng_cmd     (eng_cmd),
        .eng_bus     (eng_bus),
        .eng_tx_addr (eng_tx_addr),
        .eng_rx_addr (eng_rx_addr),
        .eng_done    (eng_done),
        .busy        (busy),
        .cur_addr    (cur_addr),
        .ev_desc     (ev_desc),
        .ev_chain    (ev_chain),
        .ev_err      (ev_err)
    );

endmodule

// File: tb/spi_chain_seq_bench.sv
module spi_chain_seq_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        sync_in = 1'b0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_valid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        eng_start;
    logic [31:0] eng_cmd, eng_bus;
    logic [63:0] eng_tx_addr, eng_rx_addr;
    logic        eng_done = 1'b0;
    logic        irq;

    int total = 0;
    int bad = 0;
    int starts = 0;
    int exp_desc = 0;
    int widx = 0;
    int exec_desc = 0;
    logic [31:0] mem_w [64];
    logic [31:0] rd_v;

    always #5 clk = ~clk;

    spi_chain_seq u_spi_chain_seq (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sync_in(sync_in),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid),
        .mem_rdata(mem_rdata), .eng_start(eng_start), .eng_cmd(eng_cmd),
        .eng_bus(eng_bus), .eng_tx_addr(eng_tx_addr), .eng_rx_addr(eng_rx_addr),
        .eng_done(eng_done), .irq(irq)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // memory and engine responder plus per-clock address model
    always @(negedge clk) begin
        if (rst_n && eng_start) begin
            int e;
            e = exec_desc >> 2;
            starts++;
            chk("R4 cmd", {32'h0, eng_cmd}, {32'h0, mem_w[e]});
            chk("R4 bus", {32'h0, eng_bus}, {32'h0, mem_w[e+1]});
            chk("R4 tx", eng_tx_addr, {mem_w[e+3], mem_w[e+2]});
            chk("R4 rx", eng_rx_addr, {mem_w[e+5], mem_w[e+4]});
        end
        if (rst_n && mem_req && !mem_valid) begin
            chk("R3 word address", {32'h0, mem_addr}, 64'(exp_desc + 4 * widx));
            mem_valid <= 1'b1;
            mem_rdata <= mem_w[mem_addr[7:2]];
            widx++;
            if (widx == 6) begin
                exec_desc = exp_desc;
                exp_desc += 24;
                widx = 0;
            end
        end else begin
            mem_valid <= 1'b0;
        end
    end

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic done_pulse();
        @(negedge clk); eng_done = 1'b1;
        @(negedge clk); eng_done = 1'b0;
    endtask

    task automatic wait_starts(input int n);
        for (int i = 0; i < 200 && starts < n; i++) @(negedge clk);
    endtask

    task automatic idle_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #1_000_000;
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        int s0;
        int req_seen;
        for (int i = 0; i < 64; i++) mem_w[i] = 32'(i) * 32'h01010101;
        // descriptor at 0x40: 16 blocks, chain continues
        mem_w[16] = 32'h0000_0010; mem_w[17] = 32'h1111_2222;
        mem_w[18] = 32'hA000_0000; mem_w[19] = 32'h0000_0001;
        mem_w[20] = 32'hB000_0000; mem_w[21] = 32'h0000_0002;
        // descriptor at 0x58: 3 blocks, end of chain (bit 30)
        mem_w[22] = 32'h4000_0003; mem_w[23] = 32'h3333_4444;
        mem_w[24] = 32'hA000_1000; mem_w[25] = 32'h0000_0001;
        mem_w[26] = 32'hB000_1000; mem_w[27] = 32'h0000_0002;
        // descriptor at 0x80: zero blocks, no end flag
        mem_w[32] = 32'h0000_0000;

        idle_cycles(3);
        rst_n = 1'b1;
        idle_cycles(2);

        // R1 reset state
        rd(5'h00, rd_v); chk("R1 claim flag", 64'(rd_v), 64'h1);
        rd(5'h14, rd_v); chk("R1 status", 64'(rd_v), 64'h0);
        rd(5'h18, rd_v); chk("R1 enable", 64'(rd_v), 64'h0);
        rd(5'h0C, rd_v); chk("R1 control", 64'(rd_v), 64'h0);
        chk("R1 irq/req/start", {61'h0, irq, mem_req, eng_start}, 64'h0);

        // R2 claim flag
        wr(5'h00, 32'h0); rd(5'h00, rd_v); chk("R2 claimed", 64'(rd_v), 64'h0);
        wr(5'h00, 32'h1); rd(5'h00, rd_v); chk("R2 released", 64'(rd_v), 64'h1);
        rd(5'h0C, rd_v); chk("R2 no launch", 64'(rd_v), 64'h0);
        rd(5'h14, rd_v); chk("R2 no status", 64'(rd_v), 64'h0);

        // R3 R5 R6 R12 two-descriptor chain
        wr(5'h18, 32'h0000_0D00);
        wr(5'h08, 32'h40);
        exp_desc = 'h40; widx = 0;
        wr(5'h0C, 32'h8000_0000);
        wait_starts(1);
        chk("R3 first start", 64'(starts), 64'd1);
        rd(5'h0C, rd_v); chk("R3 busy bit", 64'(rd_v), 64'h8000_0000);
        rd(5'h10, rd_v); chk("R12 current first", 64'(rd_v), 64'h40);
        rd(5'h14, rd_v); chk("R5 status before done", 64'(rd_v), 64'h0);
        done_pulse();
        wait_starts(2);
        chk("R5 second start", 64'(starts), 64'd2);
        rd(5'h10, rd_v); chk("R12 current second", 64'(rd_v), 64'h58);
        rd(5'h14, rd_v); chk("R5 desc done bit", 64'(rd_v), 64'h400);
        done_pulse();
        idle_cycles(3);
        rd(5'h0C, rd_v); chk("R6 idle after end", 64'(rd_v), 64'h0);
        rd(5'h14, rd_v); chk("R6 chain done", 64'(rd_v), 64'hC00);
        chk("R11 irq set", {63'h0, irq}, 64'h1);

        // R10 R11 clear and mask
        wr(5'h14, 32'h400);
        rd(5'h14, rd_v); chk("R10 partial clear", 64'(rd_v), 64'h800);
        chk("R11 irq held", {63'h0, irq}, 64'h1);
        wr(5'h18, 32'h400);
        idle_cycles(1);
        chk("R11 irq masked", {63'h0, irq}, 64'h0);
        wr(5'h18, 32'hD00);
        idle_cycles(1);
        chk("R11 irq unmasked", {63'h0, irq}, 64'h1);
        wr(5'h14, 32'h0);
        rd(5'h14, rd_v); chk("R10 zero write keeps", 64'(rd_v), 64'h800);
        wr(5'h14, 32'h800);
        rd(5'h14, rd_v); chk("R10 cleared", 64'(rd_v), 64'h0);
        chk("R11 irq low", {63'h0, irq}, 64'h0);

        // R7 zero-block descriptor
        s0 = starts;
        wr(5'h08, 32'h80);
        exp_desc = 'h80; widx = 0;
        wr(5'h0C, 32'h8000_0000);
        idle_cycles(25);
        chk("R7 no start", 64'(starts), 64'(s0));
        rd(5'h14, rd_v); chk("R7 error only", 64'(rd_v), 64'h100);
        rd(5'h0C, rd_v); chk("R7 chain ended", 64'(rd_v), 64'h0);
        wr(5'h14, 32'hFFF);

        // R8 abort
        wr(5'h08, 32'h40);
        exp_desc = 'h40; widx = 0;
        s0 = starts;
        wr(5'h0C, 32'h8000_0000);
        wait_starts(s0 + 1);
        wr(5'h0C, 32'h0);
        req_seen = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (mem_req) req_seen++;
        end
        chk("R8 no reads", 64'(req_seen), 64'h0);
        rd(5'h0C, rd_v); chk("R8 idle", 64'(rd_v), 64'h0);
        done_pulse();
        idle_cycles(3);
        rd(5'h14, rd_v); chk("R8 status unchanged", 64'(rd_v), 64'h0);
        chk("R8 no extra start", 64'(starts), 64'(s0 + 1));

        // R9 sync start, disabled then enabled
        s0 = starts;
        exp_desc = 'h40; widx = 0;
        @(negedge clk) sync_in = 1'b1;
        idle_cycles(2); sync_in = 1'b0;
        idle_cycles(20);
        rd(5'h0C, rd_v); chk("R9 sync ignored", 64'(rd_v), 64'h0);
        chk("R9 no start when off", 64'(starts), 64'(s0));
        wr(5'h04, 32'h1);
        @(negedge clk) sync_in = 1'b1;
        idle_cycles(2); sync_in = 1'b0;
        wait_starts(s0 + 1);
        chk("R9 sync launch", 64'(starts), 64'(s0 + 1));
        rd(5'h10, rd_v); chk("R9 R12 base", 64'(rd_v), 64'h40);
        done_pulse();
        wait_starts(s0 + 2);
        done_pulse();
        idle_cycles(3);
        rd(5'h14, rd_v); chk("R9 chain done", 64'(rd_v), 64'hC00);

        finish_run();
    end

endmodule